// File: doc/BRIEF.md
# Connection Memory Block-Fill Controller

This block fills every entry of a pair of connection memories with one pattern under software control. Each entry has a low word and a high word. A fill gives each low word a 3-bit pattern in its least significant bits with zeros above it, and gives each high word all zeros. Software holds the pattern and a start bit in one mode register. A separate enable input, driven from another control register, must be high when the start bit rises. A frame pulse sets the timing: the fill waits for the next frame boundary, writes one entry per clock, and reports completion after two frames.

Software polls the start bit to see whether a fill has finished. The block clears that bit itself when the fill completes or is aborted. A fill stops at once if software clears the start bit or drops the enable. While a fill is pending or running, the block raises a busy output and drops ordinary processor writes to the memories. The other mode bits in the register are stored and read back only.

Top module: `cm_fill_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0000, busy is low and neither memory write strobe is asserted.
- R2: The mode register sits at register address 1. Bit 0 is the start bit, bits 3:1 are the fill pattern and bits 8:4 are stored mode bits. Bits 15:9 always read 0. A write to any other address changes nothing, and a read from any other address returns 0.
- R3: A fill is armed only by a write that sets bit 0 while the stored start bit is 0 and the enable input is high. Busy rises on the clock edge that takes that write. If the enable is low, the start bit is stored but no fill runs, and raising the enable later does not start one.
- R4: The first write comes in the cycle after the first frame pulse that follows the trigger. One entry is written per clock, in ascending address order from 0 to DEPTH-1. Both memories are written in the same cycle at the same address: the low word is the pattern zero-extended to 16 bits, and the high word is 0x0000.
- R5: The start bit and busy clear on the edge of the second frame pulse counted after the pulse that began the fill. If the last entry is written later than that pulse, they clear one cycle after the last write instead.
- R6: The fill pattern is taken from the triggering write itself. Later writes that change bits 3:1 during a pending or running fill are stored and read back, but they do not change the data written.
- R7: A register write that clears bit 0 during a fill aborts it. No memory write occurs in that cycle or after it. Busy and the start bit are 0 from the next cycle on, and entries already written keep the fill data.
- R8: Dropping the enable input during a pending or running fill aborts it in the same way as R7, and the start bit reads 0 afterwards.
- R9: With busy low, a processor memory write goes to the low memory when the select input is 0, and to the high memory when it is 1. With busy high, processor memory writes are dropped.
- R10: Register reads show the live start bit: 1 while a fill is pending or running, and 0 once it has completed or been aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_pulse | input | 1 | One-cycle frame boundary pulse |
| fill_en | input | 1 | Block-fill enable from another control register |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | REG_AW | Register address |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data for cpu_addr |
| cpu_mem_we | input | 1 | Processor memory write strobe |
| cpu_mem_hi | input | 1 | Memory select: 0 low memory, 1 high memory |
| cpu_mem_addr | input | MEM_AW | Processor memory address |
| cpu_mem_wdata | input | DATA_W | Processor memory write data |
| mem_lo_we | output | 1 | Low memory write strobe |
| mem_lo_addr | output | MEM_AW | Low memory address |
| mem_lo_wdata | output | DATA_W | Low memory write data |
| mem_hi_we | output | 1 | High memory write strobe |
| mem_hi_addr | output | MEM_AW | High memory address |
| mem_hi_wdata | output | DATA_W | High memory write data |
| busy | output | 1 | A fill is pending or running |

## Verification
The bench builds the block with DEPTH set to 16 and a 4-bit register address. At that depth a whole fill, every entry of both memories and both frame boundaries fit in a few dozen cycles, so the bench can compare every word after each run. Because the bench drives each frame pulse itself, it can choose frame periods longer than the depth, where the second frame pulse ends the fill, and shorter than the depth, where the last write ends it. It can also place aborts at exact write counts.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

  // Mode register layout: start bit, pattern field, stored mode bits.
  localparam int PAT_W  = 3;
  localparam int MODE_W = 5;
  localparam int CFG_W  = 1 + PAT_W + MODE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_HOLD = 2'd3
  } fill_state_e;

endpackage

// File: rtl/cmf_rst_sync.sv
module cmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cmf_regfile.sv
module cmf_regfile
  import cmf_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 16,
  parameter int MODE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hw_clr,
  output logic              start_q,
  output logic [PAT_W-1:0]  wr_pat,
  output logic              start_rise,
  output logic              sw_clr,
  output logic [DATA_W-1:0] cpu_rdata
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;
  logic             sel;
  logic             wr_sel;
  logic             unused_wdata;

  assign sel          = (cpu_addr == REG_AW'(MODE_ADDR));
  assign wr_sel       = cpu_wr && sel;
  assign unused_wdata = ^cpu_wdata[DATA_W-1:CFG_W];

  // Next state: software write first, a hardware clear of the start bit wins.
  always_comb begin
    cfg_d = cfg_q;
    if (wr_sel) begin
      cfg_d = cpu_wdata[CFG_W-1:0];
    end
    if (hw_clr) begin
      cfg_d[0] = 1'b0;
    end
  end

  assign cfg_en = wr_sel || hw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign start_q    = cfg_q[0];
  assign wr_pat     = cpu_wdata[PAT_W:1];
  assign start_rise = wr_sel && cpu_wdata[0] && !cfg_q[0];
  assign sw_clr     = wr_sel && !cpu_wdata[0];
  assign cpu_rdata  = sel ? {{(DATA_W-CFG_W){1'b0}}, cfg_q} : '0;

  // R5: a completion or abort always leaves the start bit low.
  assert_hw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !start_q);

  // R2: the stored bits move only on a write to this register or a hardware clear.
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel && !hw_clr) |=> $stable(cfg_q));

endmodule

// File: rtl/cmf_sequencer.sv
module cmf_sequencer
  import cmf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int MEM_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic              fill_en,
  input  logic              start_rise,
  input  logic              sw_clr,
  input  logic [PAT_W-1:0]  wr_pat,
  output logic              busy,
  output logic              fill_we,
  output logic [MEM_AW-1:0] fill_addr,
  output logic [PAT_W-1:0]  fill_pat,
  output logic              hw_clr
);

  localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(DEPTH - 1);
  localparam logic [1:0]        FRAMES    = 2'd2;

  fill_state_e       state_q, state_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [1:0]        fcnt_q, fcnt_d;
  logic [PAT_W-1:0]  pat_q, pat_d;
  logic              pat_en;
  logic              active;
  logic              abort;
  logic              done;
  logic              frame_inc;

  assign active    = (state_q != ST_IDLE);
  assign abort     = active && (!fill_en || sw_clr);
  assign frame_inc = frame_pulse && (fcnt_q != FRAMES);
  assign done      = (state_q == ST_HOLD) &&
                     ((fcnt_q == FRAMES) || ((fcnt_q == FRAMES - 2'd1) && frame_pulse));

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    fcnt_d  = fcnt_q;
    pat_d   = pat_q;
    addr_en = 1'b0;
    pat_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_rise && fill_en) begin
          state_d = ST_ARM;
          pat_d   = wr_pat;
          pat_en  = 1'b1;
        end
      end
      ST_ARM: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (frame_pulse) begin
          state_d = ST_RUN;
          addr_d  = '0;
          addr_en = 1'b1;
          fcnt_d  = 2'd0;
        end
      end
      ST_RUN: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else begin
          if (frame_inc) begin
            fcnt_d = fcnt_q + 2'd1;
          end
          if (addr_q == LAST_ADDR) begin
            state_d = ST_HOLD;
          end else begin
            addr_d  = addr_q + 1'b1;
            addr_en = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (abort || done) begin
          state_d = ST_IDLE;
        end else if (frame_inc) begin
          fcnt_d = fcnt_q + 2'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      fcnt_q  <= fcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (pat_en) begin
      pat_q <= pat_d;
    end
  end

  assign busy      = active;
  assign fill_we   = (state_q == ST_RUN) && !abort;
  assign fill_addr = addr_q;
  assign fill_pat  = pat_q;
  assign hw_clr    = abort || done;

  // R4: consecutive fill writes step the address by one.
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (!fill_we || (fill_addr == $past(fill_addr) + 1'b1)));

  // R4: a fill always starts writing at address zero.
  assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_we) |-> (fill_addr == '0));

  // R6: the latched pattern does not move while a fill is in progress.
  assert_pat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(fill_pat)));

  // R7: a software clear of the start bit ends the fill.
  assert_sw_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && busy) |=> !busy);

  // R8: with the enable low, the block is idle on the following cycle.
  assert_en_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> !busy);

endmodule

// File: rtl/cmf_wport.sv
module cmf_wport
  import cmf_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int DATA_W = 16
) (
  input  logic              busy,
  input  logic              fill_we,
  input  logic [MEM_AW-1:0] fill_addr,
  input  logic [PAT_W-1:0]  fill_pat,
  input  logic              cpu_mem_we,
  input  logic              cpu_mem_hi,
  input  logic [MEM_AW-1:0] cpu_mem_addr,
  input  logic [DATA_W-1:0] cpu_mem_wdata,
  output logic              lo_we,
  output logic [MEM_AW-1:0] lo_addr,
  output logic [DATA_W-1:0] lo_wdata,
  output logic              hi_we,
  output logic [MEM_AW-1:0] hi_addr,
  output logic [DATA_W-1:0] hi_wdata
);

  logic [DATA_W-1:0] fill_lo_word;

  assign fill_lo_word = {{(DATA_W-PAT_W){1'b0}}, fill_pat};

  // The fill owns both ports; otherwise an idle block forwards processor writes.
  always_comb begin
    lo_we    = 1'b0;
    hi_we    = 1'b0;
    lo_addr  = cpu_mem_addr;
    hi_addr  = cpu_mem_addr;
    lo_wdata = cpu_mem_wdata;
    hi_wdata = cpu_mem_wdata;
    if (fill_we) begin
      lo_we    = 1'b1;
      hi_we    = 1'b1;
      lo_addr  = fill_addr;
      hi_addr  = fill_addr;
      lo_wdata = fill_lo_word;
      hi_wdata = '0;
    end else if (cpu_mem_we && !busy) begin
      lo_we = !cpu_mem_hi;
      hi_we = cpu_mem_hi;
    end
  end

endmodule

// File: rtl/cm_fill_ctrl.sv
module cm_fill_ctrl
  import cmf_pkg::*;
#(
  parameter  int DEPTH     = 2048,
  parameter  int REG_AW    = 4,
  parameter  int DATA_W    = 16,
  parameter  int MODE_ADDR = 1,
  localparam int MEM_AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic              fill_en,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cpu_mem_we,
  input  logic              cpu_mem_hi,
  input  logic [MEM_AW-1:0] cpu_mem_addr,
  input  logic [DATA_W-1:0] cpu_mem_wdata,
  output logic              mem_lo_we,
  output logic [MEM_AW-1:0] mem_lo_addr,
  output logic [DATA_W-1:0] mem_lo_wdata,
  output logic              mem_hi_we,
  output logic [MEM_AW-1:0] mem_hi_addr,
  output logic [DATA_W-1:0] mem_hi_wdata,
  output logic              busy
);

  logic              rst_sync_n;
  logic              start_q;
  logic [PAT_W-1:0]  wr_pat;
  logic              start_rise;
  logic              sw_clr;
  logic              hw_clr;
  logic              fill_we;
  logic [MEM_AW-1:0] fill_addr;
  logic [PAT_W-1:0]  fill_pat;

  cmf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  cmf_regfile #(
    .REG_AW   (REG_AW),
    .DATA_W   (DATA_W),
    .MODE_ADDR(MODE_ADDR)
  ) u_regfile (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .hw_clr    (hw_clr),
    .start_q   (start_q),
    .wr_pat    (wr_pat),
    .start_rise(start_rise),
    .sw_clr    (sw_clr),
    .cpu_rdata (cpu_rdata)
  );

  cmf_sequencer #(
    .DEPTH (DEPTH),
    .MEM_AW(MEM_AW)
  ) u_sequencer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_pulse(frame_pulse),
    .fill_en    (fill_en),
    .start_rise (start_rise),
    .sw_clr     (sw_clr),
    .wr_pat     (wr_pat),
    .busy       (busy),
    .fill_we    (fill_we),
    .fill_addr  (fill_addr),
    .fill_pat   (fill_pat),
    .hw_clr     (hw_clr)
  );

  cmf_wport #(
    .MEM_AW(MEM_AW),
    .DATA_W(DATA_W)
  ) u_wport (
    .busy         (busy),
    .fill_we      (fill_we),
    .fill_addr    (fill_addr),
    .fill_pat     (fill_pat),
    .cpu_mem_we   (cpu_mem_we),
    .cpu_mem_hi   (cpu_mem_hi),
    .cpu_mem_addr (cpu_mem_addr),
    .cpu_mem_wdata(cpu_mem_wdata),
    .lo_we        (mem_lo_we),
    .lo_addr      (mem_lo_addr),
    .lo_wdata     (mem_lo_wdata),
    .hi_we        (mem_hi_we),
    .hi_addr      (mem_hi_addr),
    .hi_wdata     (mem_hi_wdata)
  );

  // R9: while busy, the only memory writes are those of the fill itself.
  assert_cpu_block_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !fill_we) |-> (!mem_lo_we && !mem_hi_we));

  // R10: a pending or running fill always shows the start bit as set.
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> start_q);

  // R1: nothing is written to either memory on the first cycle out of reset.
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (!mem_lo_we && !mem_hi_we && !busy));

endmodule

// File: tb/cm_fill_ctrl_tb.sv
`timescale 1ns/1ps
module cm_fill_ctrl_tb;

  localparam int DEPTH  = 16;
  localparam int REG_AW = 4;
  localparam int DATA_W = 16;
  localparam int MEM_AW = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_pulse = 1'b0;
  logic              fill_en = 1'b0;
  logic              cpu_wr = 1'b0;
  logic [REG_AW-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic              cpu_mem_we = 1'b0;
  logic              cpu_mem_hi = 1'b0;
  logic [MEM_AW-1:0] cpu_mem_addr = '0;
  logic [DATA_W-1:0] cpu_mem_wdata = '0;
  logic              mem_lo_we;
  logic [MEM_AW-1:0] mem_lo_addr;
  logic [DATA_W-1:0] mem_lo_wdata;
  logic              mem_hi_we;
  logic [MEM_AW-1:0] mem_hi_addr;
  logic [DATA_W-1:0] mem_hi_wdata;
  logic              busy;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cm_fill_ctrl #(
    .DEPTH (DEPTH),
    .REG_AW(REG_AW),
    .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .fill_en(fill_en),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_mem_we(cpu_mem_we), .cpu_mem_hi(cpu_mem_hi), .cpu_mem_addr(cpu_mem_addr),
    .cpu_mem_wdata(cpu_mem_wdata),
    .mem_lo_we(mem_lo_we), .mem_lo_addr(mem_lo_addr), .mem_lo_wdata(mem_lo_wdata),
    .mem_hi_we(mem_hi_we), .mem_hi_addr(mem_hi_addr), .mem_hi_wdata(mem_hi_wdata),
    .busy(busy)
  );

  // Memory models built from the write ports.
  logic [DATA_W-1:0] lo_m [DEPTH];
  logic [DATA_W-1:0] hi_m [DEPTH];
  int lo_cnt = 0;
  int hi_cnt = 0;
  int ord_err = 0;
  int last_a = 0;

  always @(posedge clk) begin
    if (mem_lo_we) begin
      lo_m[mem_lo_addr] <= mem_lo_wdata;
      lo_cnt <= lo_cnt + 1;
    end
    if (mem_hi_we) begin
      hi_m[mem_hi_addr] <= mem_hi_wdata;
      hi_cnt <= hi_cnt + 1;
    end
    if (mem_lo_we && mem_hi_we) begin
      if (mem_lo_addr != mem_hi_addr) ord_err <= ord_err + 1;
      else if (mem_lo_addr != 0 && int'(mem_lo_addr) != last_a + 1) ord_err <= ord_err + 1;
      last_a <= int'(mem_lo_addr);
    end
  end

  function automatic logic [15:0] cfg_word(input int pat, input int mode, input bit st);
    return {7'b0, 5'(mode), 3'(pat), st};
  endfunction

  function automatic logic [15:0] fill_lo(input int pat);
    return {13'b0, 3'(pat)};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit pulse);
    frame_pulse = pulse;
    @(negedge clk);
    frame_pulse = 1'b0;
  endtask

  task automatic reg_write(input int a, input logic [15:0] d);
    cpu_wr = 1'b1;
    cpu_addr = REG_AW'(a);
    cpu_wdata = d;
    step(1'b0);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    cpu_addr = REG_AW'(a);
    #1;
    v = int'(cpu_rdata);
  endtask

  task automatic mem_write(input bit hi, input int a, input logic [15:0] d);
    cpu_mem_we = 1'b1;
    cpu_mem_hi = hi;
    cpu_mem_addr = MEM_AW'(a);
    cpu_mem_wdata = d;
    step(1'b0);
    cpu_mem_we = 1'b0;
  endtask

  task automatic check_contents(input string req, input int pat);
    int bad_lo = 0;
    int bad_hi = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lo_m[i] !== fill_lo(pat)) bad_lo++;
      if (hi_m[i] !== 16'h0000) bad_hi++;
    end
    chk(req, "low words off pattern", bad_lo, 0);
    chk(req, "high words nonzero", bad_hi, 0);
  endtask

  // Full fill with frame period per (per >= 9 so the writes end before the second pulse).
  task automatic full_fill(input int pat, input int mode, input int per);
    int base;
    int v;
    base = lo_cnt;
    reg_write(1, cfg_word(pat, mode, 1'b1));
    chk("R3", "busy after trigger", int'(busy), 1);
    step(1'b1);
    for (int k = 1; k <= 2 * per; k++) begin
      step(k == per || k == 2 * per);
      if (k == DEPTH) chk("R4", "writes after depth cycles", lo_cnt - base, DEPTH);
      if (k == 2 * per - 1) chk("R5", "busy before second pulse", int'(busy), 1);
    end
    chk("R5", "busy after second pulse", int'(busy), 0);
    rd(1, v);
    chk("R10", "start bit after completion", v, int'(cfg_word(pat, mode, 1'b0)));
    check_contents("R4", pat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    int v;
    int base;
    int hbase;
    int seed_val;
    logic [15:0] w;
    seed_val = $urandom(32'd4242);

    // Reset, released away from the clock edge.
    repeat (3) step(1'b0);
    rst_n = 1'b1;
    repeat (4) step(1'b0);

    // R1: reset state.
    rd(1, v);
    chk("R1", "mode register after reset", v, 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "memory writes after reset", lo_cnt + hi_cnt, 0);

    // R2: register storage and decoding.
    reg_write(1, 16'hFFFE);
    rd(1, v);
    chk("R2", "upper bits read zero", v, 16'h01FE);
    reg_write(2, 16'hFFFF);
    rd(2, v);
    chk("R2", "other address reads zero", v, 0);
    rd(1, v);
    chk("R2", "other address write ignored", v, 16'h01FE);
    for (int i = 0; i < 8; i++) begin
      w = 16'($urandom) & 16'hFFFE;
      reg_write(1, w);
      rd(1, v);
      chk("R2", "random readback", v, int'(w & 16'h01FE));
    end
    chk("R2", "no fill from start-low writes", lo_cnt + hi_cnt, 0);
    reg_write(1, 16'h0000);

    // R3: trigger with the enable low does nothing, nor does a later enable.
    fill_en = 1'b0;
    base = lo_cnt;
    reg_write(1, cfg_word(5, 0, 1'b1));
    chk("R3", "busy with enable low", int'(busy), 0);
    rd(1, v);
    chk("R3", "start stored with enable low", v, int'(cfg_word(5, 0, 1'b1)));
    step(1'b1);
    repeat (20) step(1'b0);
    fill_en = 1'b1;
    step(1'b1);
    repeat (20) step(1'b0);
    chk("R3", "busy after late enable", int'(busy), 0);
    chk("R3", "no writes after late enable", lo_cnt - base, 0);
    reg_write(1, 16'h0000);

    // R9: processor writes while idle reach the selected memory.
    for (int i = 0; i < DEPTH; i++) begin
      mem_write(1'b0, i, 16'hA000 | 16'(i));
      mem_write(1'b1, i, 16'hB000 | 16'(i));
    end
    chk("R9", "low word via select 0", int'(lo_m[7]), 16'hA007);
    chk("R9", "high word via select 1", int'(hi_m[9]), 16'hB009);

    // R4, R5, R6, R9, R10: directed fill with a 40-cycle frame.
    base = lo_cnt;
    hbase = hi_cnt;
    reg_write(1, cfg_word(5, 21, 1'b1));
    chk("R3", "busy on trigger edge", int'(busy), 1);
    rd(1, v);
    chk("R10", "start bit while pending", v & 1, 1);
    step(1'b0);
    reg_write(1, cfg_word(2, 21, 1'b1));
    rd(1, v);
    chk("R6", "changed pattern readback", v, int'(cfg_word(2, 21, 1'b1)));
    mem_write(1'b1, 3, 16'hBEEF);
    chk("R9", "processor write dropped while busy", hi_cnt - hbase, 0);
    step(1'b0);
    chk("R4", "no writes before frame pulse", lo_cnt - base, 0);
    step(1'b1);
    chk("R4", "no write on frame pulse edge", lo_cnt - base, 0);
    step(1'b0);
    chk("R4", "first write count", lo_cnt - base, 1);
    chk("R6", "first entry uses latched pattern", int'(lo_m[0]), int'(fill_lo(5)));
    for (int k = 2; k <= 40; k++) begin
      step(k == 40);
      if (k == DEPTH) chk("R4", "all entries written", lo_cnt - base, DEPTH);
    end
    chk("R5", "busy after first frame", int'(busy), 1);
    rd(1, v);
    chk("R10", "start bit mid-fill", v & 1, 1);
    mem_write(1'b0, 2, 16'h1234);
    for (int k = 2; k <= 40; k++) step(k == 40);
    chk("R5", "busy after second frame", int'(busy), 0);
    rd(1, v);
    chk("R5", "start cleared on completion", v, int'(cfg_word(2, 21, 1'b0)));
    check_contents("R6", 5);
    chk("R4", "write order", ord_err, 0);

    // R5: short frames, completion waits for the last write.
    base = lo_cnt;
    reg_write(1, cfg_word(3, 4, 1'b1));
    step(1'b1);
    for (int k = 1; k <= DEPTH; k++) begin
      step(k % 6 == 0);
      if (k == 12) chk("R5", "busy after early second pulse", int'(busy), 1);
    end
    chk("R5", "all written in short frames", lo_cnt - base, DEPTH);
    chk("R5", "busy on last write edge", int'(busy), 1);
    step(1'b0);
    chk("R5", "busy one cycle after last write", int'(busy), 0);
    check_contents("R5", 3);

    // R7: abort by software after five writes.
    base = lo_cnt;
    reg_write(1, cfg_word(6, 0, 1'b1));
    step(1'b1);
    repeat (5) step(1'b0);
    chk("R7", "writes before abort", lo_cnt - base, 5);
    reg_write(1, cfg_word(6, 0, 1'b0));
    chk("R7", "no write in abort cycle", lo_cnt - base, 5);
    chk("R7", "busy after abort", int'(busy), 0);
    repeat (20) step(1'b0);
    chk("R7", "no writes after abort", lo_cnt - base, 5);
    chk("R7", "written entry kept", int'(lo_m[4]), int'(fill_lo(6)));
    chk("R7", "unwritten entry untouched", int'(lo_m[5]), int'(fill_lo(3)));
    rd(1, v);
    chk("R10", "start bit after abort", v & 1, 0);

    // R8: abort by dropping the enable during the run.
    base = lo_cnt;
    reg_write(1, cfg_word(1, 0, 1'b1));
    step(1'b1);
    repeat (3) step(1'b0);
    fill_en = 1'b0;
    step(1'b0);
    chk("R8", "writes stop at enable drop", lo_cnt - base, 3);
    chk("R8", "busy after enable drop", int'(busy), 0);
    rd(1, v);
    chk("R8", "start bit after enable drop", v & 1, 0);
    fill_en = 1'b1;
    step(1'b1);
    repeat (20) step(1'b0);
    chk("R8", "no restart after enable returns", lo_cnt - base, 3);

    // R8: abort by the enable while still waiting for the frame pulse.
    base = lo_cnt;
    reg_write(1, cfg_word(7, 0, 1'b1));
    fill_en = 1'b0;
    step(1'b0);
    chk("R8", "busy after pending abort", int'(busy), 0);
    fill_en = 1'b1;
    step(1'b1);
    repeat (20) step(1'b0);
    chk("R8", "no writes after pending abort", lo_cnt - base, 0);
    rd(1, v);
    chk("R8", "start bit after pending abort", v & 1, 0);

    // Random fills with random patterns, mode bits and frame periods.
    for (int r = 0; r < 4; r++) begin
      full_fill(int'($urandom % 8), int'($urandom % 32), 10 + int'($urandom % 21));
    end
    chk("R4", "write order overall", ord_err, 0);

    summary();
  end

endmodule